// File: doc/BRIEF.md
# Host Processor Parallel Interface

This block is a byte-wide slave port that connects an external host processor to an embedded 16-bit DSP core. The host sees four byte-wide registers on a 2-bit address bus, qualified by a chip select and by read and write strobes. The DSP sees two 16-bit registers behind a one-bit select, plus interrupt and request outputs.

Data words travel in both directions through separate two-stage paths. Each path has a holding stage filled by the producer and an output stage drained by the consumer, so one word can wait while the other side is still reading the previous word. The host moves a word as two byte accesses: the high byte at address 2, then the low byte at address 3. An 8-bit host can therefore use a single 16-bit load or store instruction. Writing the low byte completes a host-to-DSP word, and reading the low byte consumes a DSP-to-host word.

A command register lets the host pick one of 31 DSP exception routines by writing a 5-bit vector number and setting a request bit. The request is presented to the DSP with its vector until the DSP acknowledges it.

The host bus is sampled synchronously: each access is a single clock cycle with the strobe high. The read data `hdata_o` and `dsp_rdata_o` are combinational on the current address or select. Only the strobed edge has side effects.

Top module: `host_pif`

## Requirements
- R1: After reset, the following hold: no receive word is pending, no transmit word is pending, both holding stages are empty, the vector is 0, no command is pending, and `rx_irq_o` and `cmd_req_o` are low.
- R2: A host write to address 2 followed by a write to address 3 forms the word {addr2 byte, addr3 byte}. This word reaches the DSP data register (select 0). The receive-full flag is still 0 after the clock edge that takes the low byte. It is 1 after the following edge. A DSP read with `dsp_re_i` at select 0 clears it on that edge.
- R3: A write to address 2 alone never moves a word. When address 2 is written more than once, the last value written is used by the next low-byte write.
- R4: The receive path holds two words: one in the output stage and one in the holding stage. A low-byte write is ignored while both stages are full. Words reach the DSP in the order they were written.
- R5: A DSP write at select 0 queues a transmit word. Host status bit 0 (read data ready) is 0 after the clock edge that takes the write, and 1 after the next edge. Address 2 reads the high byte, and address 3 reads the low byte. Only a strobed read of address 3 clears the ready bit.
- R6: The transmit path holds two words. A DSP write is ignored while both stages are full. DSP control bit 1 (transmit holding empty) is 0 while the holding stage is occupied.
- R7: Host address 0 reads {5'b0, command pending, receive holding empty, read data ready}, from bit 7 down to bit 0.
- R8: A host write to address 1 stores data bits 4:0 as the vector. Data bit 7 requests a command. A read of address 1 returns {pending, 2'b00, vector}.
- R9: A command request with a nonzero vector raises `cmd_req_o`, with `cmd_vec_o` equal to the vector, after the writing edge. The request stays high until an edge with `cmd_ack_i` high clears it.
- R10: Host writes to address 1 are ignored while a command is pending. This covers both the vector and the request bit.
- R11: A request written with vector 0 stores the vector but raises no request.
- R12: `rx_irq_o` is high exactly while receive data is full and the receive interrupt enable is set. The enable is DSP control bit 0, written at select 1.
- R13: A DSP read at select 1 returns {13'b0, interrupt enable, transmit holding empty, receive full}. Bus activity with `hcs_i` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hcs_i | input | 1 | Host chip select |
| hrd_i | input | 1 | Host read strobe, one cycle per access |
| hwr_i | input | 1 | Host write strobe, one cycle per access |
| haddr_i | input | 2 | Host register address |
| hdata_i | input | 8 | Host write data |
| hdata_o | output | 8 | Host read data, combinational on `haddr_i` |
| dsp_sel_i | input | 1 | DSP register select: 0 data, 1 control/status |
| dsp_we_i | input | 1 | DSP write strobe |
| dsp_re_i | input | 1 | DSP read strobe; at select 0 it consumes the receive word |
| dsp_wdata_i | input | 16 | DSP write data |
| dsp_rdata_o | output | 16 | DSP read data, combinational on `dsp_sel_i` |
| rx_irq_o | output | 1 | Receive data interrupt |
| cmd_req_o | output | 1 | Vectored command request to the DSP |
| cmd_vec_o | output | 5 | Vector number for the pending request |
| cmd_ack_i | input | 1 | DSP acknowledge of the command request |

## Verification
Results appear on different edges. Command state, the control enable, and stage occupancy change on the edge that samples the strobe. A word needs one further edge to move from the holding stage to the output stage. Receive-full, read-data-ready and the interrupt therefore appear one cycle after the completing access. Every bench task drives on a falling edge and returns on the next falling edge. The bench reads the combinational read paths just after that falling edge. For each result, it checks both the falling edge where the old value must still be seen and the one where the new value is due.

// File: rtl/host_pif_pkg.sv
package host_pif_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 2 * BYTE_W;
  localparam int unsigned HADDR_W = 2;
  localparam int unsigned VEC_W   = 5;
  localparam int unsigned REQ_BIT = 7;

  typedef enum logic [HADDR_W-1:0] {
    HREG_STAT = 2'd0,
    HREG_VEC  = 2'd1,
    HREG_DHI  = 2'd2,
    HREG_DLO  = 2'd3
  } hreg_e;

  typedef enum logic {
    DREG_DATA = 1'b0,
    DREG_CTRL = 1'b1
  } dreg_e;
endpackage

// File: rtl/host_pif_dbuf.sv
module host_pif_dbuf #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         hold_full_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  logic [W-1:0] hold_q, out_q;
  logic         hold_full_q, out_valid_q;
  logic         xfer, push_ok, pop_ok;

  assign xfer    = hold_full_q & ~out_valid_q;
  // holding stage accepts when empty or emptying this cycle
  assign push_ok = push_i & (~hold_full_q | xfer);
  assign pop_ok  = pop_i & out_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      out_q       <= '0;
      hold_full_q <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      if (push_ok) hold_q <= push_data_i;
      if (xfer)    out_q  <= hold_q;
      hold_full_q <= push_ok | (hold_full_q & ~xfer);
      out_valid_q <= xfer | (out_valid_q & ~pop_ok);
    end
  end

  assign hold_full_o = hold_full_q;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_q;
endmodule

// File: rtl/host_pif_cmd.sv
module host_pif_cmd #(
  parameter int unsigned VW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [VW-1:0] vec_i,
  input  logic          req_i,
  input  logic          ack_i,
  output logic [VW-1:0] vec_o,
  output logic          pend_o
);
  logic [VW-1:0] vec_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      pend_q <= 1'b0;
    end else if (wr_i && !pend_q) begin
      vec_q  <= vec_i;
      pend_q <= req_i & (vec_i != '0);
    end else if (ack_i && pend_q) begin
      pend_q <= 1'b0;
    end
  end

  assign vec_o  = vec_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/host_pif.sv
module host_pif
  import host_pif_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hcs_i,
  input  logic                 hrd_i,
  input  logic                 hwr_i,
  input  logic [HADDR_W-1:0]   haddr_i,
  input  logic [BYTE_W-1:0]    hdata_i,
  output logic [BYTE_W-1:0]    hdata_o,
  input  logic                 dsp_sel_i,
  input  logic                 dsp_we_i,
  input  logic                 dsp_re_i,
  input  logic [WORD_W-1:0]    dsp_wdata_i,
  output logic [WORD_W-1:0]    dsp_rdata_o,
  output logic                 rx_irq_o,
  output logic                 cmd_req_o,
  output logic [VEC_W-1:0]     cmd_vec_o,
  input  logic                 cmd_ack_i
);
  hreg_e hreg;
  dreg_e dreg;
  logic  h_wr, h_rd;
  logic  wr_hi, wr_lo, wr_vec, rd_lo;
  logic  d_wr_data, d_wr_ctrl, d_rd_data;

  logic [BYTE_W-1:0] hi_q;
  logic              rx_ie_q;

  logic              rx_hold_full, rx_out_valid, rx_pop;
  logic [WORD_W-1:0] rx_out_data;
  logic              tx_hold_full, tx_out_valid, tx_pop;
  logic [WORD_W-1:0] tx_out_data;
  logic [VEC_W-1:0]  vec;
  logic              pend;

  assign hreg = hreg_e'(haddr_i);
  assign dreg = dreg_e'(dsp_sel_i);

  assign h_wr   = hcs_i & hwr_i;
  assign h_rd   = hcs_i & hrd_i;
  assign wr_hi  = h_wr & (hreg == HREG_DHI);
  assign wr_lo  = h_wr & (hreg == HREG_DLO);
  assign wr_vec = h_wr & (hreg == HREG_VEC);
  assign rd_lo  = h_rd & (hreg == HREG_DLO);

  assign d_wr_data = dsp_we_i & (dreg == DREG_DATA);
  assign d_wr_ctrl = dsp_we_i & (dreg == DREG_CTRL);
  assign d_rd_data = dsp_re_i & (dreg == DREG_DATA);

  assign rx_pop = d_rd_data;
  assign tx_pop = rd_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      rx_ie_q <= 1'b0;
    end else begin
      if (wr_hi)     hi_q    <= hdata_i;
      if (d_wr_ctrl) rx_ie_q <= dsp_wdata_i[0];
    end
  end

  // host -> DSP
  host_pif_dbuf #(.W(WORD_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_lo),
    .push_data_i ({hi_q, hdata_i}),
    .pop_i       (rx_pop),
    .hold_full_o (rx_hold_full),
    .out_valid_o (rx_out_valid),
    .out_data_o  (rx_out_data)
  );

  // DSP -> host
  host_pif_dbuf #(.W(WORD_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (d_wr_data),
    .push_data_i (dsp_wdata_i),
    .pop_i       (tx_pop),
    .hold_full_o (tx_hold_full),
    .out_valid_o (tx_out_valid),
    .out_data_o  (tx_out_data)
  );

  host_pif_cmd #(.VW(VEC_W)) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_vec),
    .vec_i  (hdata_i[VEC_W-1:0]),
    .req_i  (hdata_i[REQ_BIT]),
    .ack_i  (cmd_ack_i),
    .vec_o  (vec),
    .pend_o (pend)
  );

  always_comb begin
    hdata_o = '0;
    unique case (hreg)
      HREG_STAT: hdata_o = {{(BYTE_W-3){1'b0}}, pend, ~rx_hold_full, tx_out_valid};
      HREG_VEC:  hdata_o = {pend, {(BYTE_W-VEC_W-1){1'b0}}, vec};
      HREG_DHI:  hdata_o = tx_out_data[WORD_W-1:BYTE_W];
      HREG_DLO:  hdata_o = tx_out_data[BYTE_W-1:0];
      default:   hdata_o = '0;
    endcase
  end

  always_comb begin
    if (dreg == DREG_DATA) dsp_rdata_o = rx_out_data;
    else dsp_rdata_o = {{(WORD_W-3){1'b0}}, rx_ie_q, ~tx_hold_full, rx_out_valid};
  end

  assign rx_irq_o  = rx_out_valid & rx_ie_q;
  assign cmd_req_o = pend;
  assign cmd_vec_o = vec;
endmodule

// File: rtl/host_pif_chk.sv
module host_pif_chk #(
  parameter int unsigned VW = 5,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_req_o,
  input logic [VW-1:0] cmd_vec_o,
  input logic          cmd_ack_i,
  input logic          rx_irq_o,
  input logic          rx_valid,
  input logic          rx_pop,
  input logic [DW-1:0] rx_data,
  input logic          tx_valid,
  input logic          tx_pop
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o && !cmd_ack_i |=> cmd_req_o); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o && cmd_ack_i |=> !cmd_req_o); // R9
  AST_VEC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o && !cmd_ack_i |=> $stable(cmd_vec_o)); // R10
  AST_REQ_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |-> cmd_vec_o != '0); // R11
  AST_IRQ_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_valid); // R12
  AST_RX_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid && !rx_pop |=> rx_valid && $stable(rx_data)); // R4
  AST_TX_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid && !tx_pop |=> tx_valid); // R5
endmodule

bind host_pif host_pif_chk #(.VW(host_pif_pkg::VEC_W), .DW(host_pif_pkg::WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_req_o (cmd_req_o),
  .cmd_vec_o (cmd_vec_o),
  .cmd_ack_i (cmd_ack_i),
  .rx_irq_o  (rx_irq_o),
  .rx_valid  (rx_out_valid),
  .rx_pop    (rx_pop),
  .rx_data   (rx_out_data),
  .tx_valid  (tx_out_valid),
  .tx_pop    (tx_pop)
);

// File: tb/test_host_pif.sv
module test_host_pif;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hcs_i = 1'b0, hrd_i = 1'b0, hwr_i = 1'b0;
  logic [1:0]  haddr_i = '0;
  logic [7:0]  hdata_i = '0;
  logic [7:0]  hdata_o;
  logic        dsp_sel_i = 1'b0, dsp_we_i = 1'b0, dsp_re_i = 1'b0;
  logic [15:0] dsp_wdata_i = '0;
  logic [15:0] dsp_rdata_o;
  logic        rx_irq_o, cmd_req_o, cmd_ack_i = 1'b0;
  logic [4:0]  cmd_vec_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  host_pif i_host_pif (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks: entered at a falling edge, return at the next falling edge
  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    hcs_i = 1'b1; hwr_i = 1'b1; haddr_i = a; hdata_i = d;
    @(negedge clk_i);
    hcs_i = 1'b0; hwr_i = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    hcs_i = 1'b1; hrd_i = 1'b1; haddr_i = a;
    #1 d = hdata_o;
    @(negedge clk_i);
    hcs_i = 1'b0; hrd_i = 1'b0;
  endtask

  task automatic hpeek(input logic [1:0] a, output logic [7:0] d);
    haddr_i = a;
    #1 d = hdata_o;
  endtask

  task automatic dwrite(input logic s, input logic [15:0] d);
    dsp_sel_i = s; dsp_we_i = 1'b1; dsp_wdata_i = d;
    @(negedge clk_i);
    dsp_we_i = 1'b0;
  endtask

  task automatic dpop(output logic [15:0] d);
    dsp_sel_i = 1'b0; dsp_re_i = 1'b1;
    #1 d = dsp_rdata_o;
    @(negedge clk_i);
    dsp_re_i = 1'b0;
  endtask

  task automatic dpeek(input logic s, output logic [15:0] d);
    dsp_sel_i = s;
    #1 d = dsp_rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] h; logic [15:0] d;
    hpeek(2'd0, h); chk("R1 R7 host status", {8'h0, h}, 16'h0002);
    hpeek(2'd1, h); chk("R1 vector", {8'h0, h}, 16'h0000);
    dpeek(1'b1, d); chk("R1 R13 dsp ctrl", d, 16'h0002);
    chk("R1 irq/req", {14'h0, rx_irq_o, cmd_req_o}, 16'h0);
  endtask

  task automatic t_rx_word();
    logic [7:0] h; logic [15:0] d;
    hwrite(2'd2, 8'hAB);
    hwrite(2'd3, 8'hCD);
    dpeek(1'b1, d); chk("R2 rx_full not yet", d & 16'h1, 16'h0);
    hpeek(2'd0, h); chk("R7 holding busy", {8'h0, h}, 16'h0000);
    idle(1);
    dpeek(1'b1, d); chk("R2 rx_full set", d & 16'h1, 16'h1);
    hpeek(2'd0, h); chk("R7 holding empty again", {8'h0, h}, 16'h0002);
    dpop(d); chk("R2 word", d, 16'hABCD);
    dpeek(1'b1, d); chk("R2 rx_full cleared", d & 16'h1, 16'h0);
  endtask

  task automatic t_hi_only();
    logic [15:0] d;
    hwrite(2'd2, 8'h11);
    hwrite(2'd2, 8'h22);
    idle(3);
    dpeek(1'b1, d); chk("R3 no word from high byte", d & 16'h1, 16'h0);
    // strobes without chip select do nothing
    hcs_i = 1'b0; hwr_i = 1'b1; haddr_i = 2'd3; hdata_i = 8'h77;
    @(negedge clk_i); hwr_i = 1'b0;
    idle(2);
    dpeek(1'b1, d); chk("R13 no cs ignored", d & 16'h1, 16'h0);
    hwrite(2'd3, 8'h33);
    idle(1);
    dpop(d); chk("R3 last high byte used", d, 16'h2233);
  endtask

  task automatic t_rx_dbl();
    logic [7:0] h; logic [15:0] d;
    hwrite(2'd2, 8'h01); hwrite(2'd3, 8'h02);
    hwrite(2'd2, 8'h03); hwrite(2'd3, 8'h04);
    hwrite(2'd2, 8'h05); hwrite(2'd3, 8'h06);
    hpeek(2'd0, h); chk("R4 both stages full", {8'h0, h} & 16'h2, 16'h0);
    dpop(d); chk("R4 first word", d, 16'h0102);
    idle(1);
    dpop(d); chk("R4 second word", d, 16'h0304);
    idle(2);
    dpeek(1'b1, d); chk("R4 third word dropped", d & 16'h1, 16'h0);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    dwrite(1'b1, 16'h0001);
    dpeek(1'b1, d); chk("R13 ie bit", d, 16'h0006);
    hwrite(2'd2, 8'h5A); hwrite(2'd3, 8'hA5);
    chk("R12 irq not yet", {15'h0, rx_irq_o}, 16'h0);
    idle(1);
    chk("R12 irq set", {15'h0, rx_irq_o}, 16'h1);
    dpop(d);
    chk("R12 irq cleared by read", {15'h0, rx_irq_o}, 16'h0);
    dwrite(1'b1, 16'h0000);
    hwrite(2'd2, 8'h00); hwrite(2'd3, 8'h01);
    idle(2);
    dpeek(1'b1, d); chk("R12 full but disabled", d & 16'h1, 16'h1);
    chk("R12 irq masked", {15'h0, rx_irq_o}, 16'h0);
    dpop(d);
  endtask

  task automatic t_tx();
    logic [7:0] h; logic [15:0] d;
    dwrite(1'b0, 16'h1234);
    hpeek(2'd0, h); chk("R5 ready not yet", {8'h0, h} & 16'h1, 16'h0);
    dpeek(1'b1, d); chk("R6 tx hold busy", d & 16'h2, 16'h0);
    idle(1);
    hpeek(2'd0, h); chk("R5 ready set", {8'h0, h} & 16'h1, 16'h1);
    dpeek(1'b1, d); chk("R6 tx hold empty", d & 16'h2, 16'h2);
    hread(2'd2, h); chk("R5 high byte", {8'h0, h}, 16'h0012);
    hpeek(2'd0, h); chk("R5 high read keeps ready", {8'h0, h} & 16'h1, 16'h1);
    hread(2'd3, h); chk("R5 low byte", {8'h0, h}, 16'h0034);
    hpeek(2'd0, h); chk("R5 ready cleared", {8'h0, h} & 16'h1, 16'h0);
  endtask

  task automatic t_tx_dbl();
    logic [7:0] h; logic [15:0] d;
    dwrite(1'b0, 16'hA1A2);
    dwrite(1'b0, 16'hB1B2);
    dwrite(1'b0, 16'hC1C2);
    dpeek(1'b1, d); chk("R6 both full", d & 16'h2, 16'h0);
    hread(2'd2, h); chk("R6 first high", {8'h0, h}, 16'h00A1);
    hread(2'd3, h); chk("R6 first low", {8'h0, h}, 16'h00A2);
    idle(1);
    hread(2'd2, h); chk("R6 second high", {8'h0, h}, 16'h00B1);
    hread(2'd3, h); chk("R6 second low", {8'h0, h}, 16'h00B2);
    idle(2);
    hpeek(2'd0, h); chk("R6 third dropped", {8'h0, h} & 16'h1, 16'h0);
  endtask

  task automatic t_cmd();
    logic [7:0] h;
    hwrite(2'd1, 8'h85);
    chk("R9 request", {10'h0, cmd_req_o, cmd_vec_o}, 16'h0025);
    hpeek(2'd1, h); chk("R8 vector readback", {8'h0, h}, 16'h0085);
    hpeek(2'd0, h); chk("R7 pending bit", {8'h0, h} & 16'h4, 16'h4);
    hwrite(2'd1, 8'h9F);
    idle(2);
    chk("R10 write ignored", {10'h0, cmd_req_o, cmd_vec_o}, 16'h0025);
    cmd_ack_i = 1'b1; @(negedge clk_i); cmd_ack_i = 1'b0;
    chk("R9 ack clears", {15'h0, cmd_req_o}, 16'h0);
    hpeek(2'd1, h); chk("R9 readback after ack", {8'h0, h}, 16'h0005);
    hwrite(2'd1, 8'h03);
    hpeek(2'd1, h); chk("R8 vector without request", {8'h0, h}, 16'h0003);
    chk("R8 no request", {15'h0, cmd_req_o}, 16'h0);
    hwrite(2'd1, 8'h80);
    hpeek(2'd1, h); chk("R11 vector zero", {8'h0, h}, 16'h0000);
    chk("R11 no request", {15'h0, cmd_req_o}, 16'h0);
    hwrite(2'd1, 8'h9F);
    chk("R9 vector 31", {10'h0, cmd_req_o, cmd_vec_o}, 16'h003F);
    cmd_ack_i = 1'b1; @(negedge clk_i); cmd_ack_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rx_word();
    t_hi_only();
    t_rx_dbl();
    t_irq();
    t_tx();
    t_tx_dbl();
    t_cmd();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule